// File: doc/BRIEF.md
# Test Vector Force/Compare Engine

This block plays a loaded table of test vectors against a device, one vector for each tester cycle. Each vector holds one data bit for each channel and selects one of a small set of templates. The template gives every channel a role for that cycle. A channel in the force role drives the vector bit onto the pin. A channel in the compare role checks the sampled pin against the vector bit. A channel in the mask role does neither, and its sampled value is ignored. Because the role is chosen per vector, a bidirectional pin can drive in one cycle and be checked in the next.

Channels are grouped into sectors. Channel `c` is lane `c % SECT_CH` of sector `c / SECT_CH`, and one compare slice is built for each sector. Software loads the templates and the vectors through two write ports, sets the index of the last vector, and pulses start. The engine then runs through the vectors in order. Each vector first spends one settle clock, then waits in a compare phase for the strobe from the timing block. Mismatches are counted into a saturating total. The engine also records the index of the first failing vector and keeps a fail flag for every vector, which can be read back by address. After the last vector the engine raises done and stops driving.

Top module: `vfc_engine`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `done_o`, `drive_en_o`, `err_cnt_o` and `first_fail_vld_o` are all zero.
- R2: The code for channel c is held in template bits [2c+1:2c]. Code 01 (force) sets `drive_en_o[c]` and drives the vector bit on `drive_val_o[c]`. Code 10 (compare) checks `pin_i[c]` against the vector bit. Codes 00 and 11 are mask: the channel is not driven and not checked. `drive_val_o[c]` is 0 whenever the channel is not forced.
- R3: Each vector starts with one settle clock, and a strobe during that clock is ignored. A channel in the compare role is never driven, neither in the clock of its strobe nor in the clock before it. This holds even when the previous vector forced that channel.
- R4: A strobe during the compare phase adds the number of mismatching compare channels to `err_cnt_o`. The engine then moves to the next vector, which enters its settle clock on the following edge.
- R5: `err_cnt_o` saturates at 2^ERR_W-1 and never wraps.
- R6: `first_fail_o` holds the index of the first vector that had any mismatch, and `first_fail_vld_o` is high once such a vector exists. Both stay fixed for the rest of the run.
- R7: `fail_flag_o` reads, with no delay, the fail flag of the vector at `fail_addr_i`. The flag is 1 when that vector had a mismatch in the current run.
- R8: The strobe of vector `last_idx_i` ends the run. `done_o` rises, every drive enable is released, and no further vector is applied.
- R9: Start is accepted only while the engine is idle. It clears the error count, the first-fail record, all fail flags and done. A start pulse during a run has no effect.
- R10: A mismatch on a masked channel (code 00 or 11) does not change the error count or the fail flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tpl_we_i | input | 1 | Template write strobe |
| tpl_addr_i | input | TPL_W | Template slot to write |
| tpl_codes_i | input | 2*NUM_CH | Two-bit role code for each channel |
| vec_we_i | input | 1 | Vector write strobe |
| vec_addr_i | input | IDX_W | Vector index to write |
| vec_tpl_i | input | TPL_W | Template selected by the vector |
| vec_data_i | input | NUM_CH | Force or expected data of the vector |
| last_idx_i | input | IDX_W | Index of the last vector in the run |
| start_i | input | 1 | Start pulse |
| done_o | output | 1 | Run finished |
| drive_val_o | output | NUM_CH | Value driven on each channel |
| drive_en_o | output | NUM_CH | Drive enable for each channel |
| pin_i | input | NUM_CH | Sampled pin value for each channel |
| strobe_i | input | 1 | Compare strobe from the timing block |
| err_cnt_o | output | ERR_W | Saturating count of mismatches |
| first_fail_o | output | IDX_W | Index of the first failing vector |
| first_fail_vld_o | output | 1 | A failing vector has been recorded |
| fail_addr_i | input | IDX_W | Vector index for fail flag readout |
| fail_flag_o | output | 1 | Fail flag of the addressed vector |

## Verification
The assertions assume that the template and vector stores, and `last_idx_i`, stay unchanged while a run is in progress. They also assume that `pin_i` has settled by the time the strobe is sampled. The bench loads every table only while the engine is idle. It changes the pins and the strobe only on falling edges, and it raises the strobe only after the settle clock, except where it deliberately tests that an early strobe is ignored. The masked channels and the forced channels receive random values, so the checks show that those channels never reach the error count.

// File: rtl/vfc_pkg.sv
package vfc_pkg;
  typedef enum logic [1:0] {
    ROLE_MASK  = 2'b00,
    ROLE_FORCE = 2'b01,
    ROLE_CMP   = 2'b10,
    ROLE_RSVD  = 2'b11
  } role_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_STROBE = 2'd2
  } state_e;
endpackage

// File: rtl/vfc_vec_store.sv
module vfc_vec_store #(
  parameter int NUM_CH = 16,
  parameter int DEPTH  = 64,
  parameter int TPL_W  = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [TPL_W-1:0]  wtpl_i,
  input  logic [NUM_CH-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [TPL_W-1:0]  rtpl_o,
  output logic [NUM_CH-1:0] rdata_o
);
  logic [TPL_W-1:0]  tpl_mem  [DEPTH];
  logic [NUM_CH-1:0] data_mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      tpl_mem[waddr_i]  <= wtpl_i;
      data_mem[waddr_i] <= wdata_i;
    end
  end

  assign rtpl_o  = tpl_mem[raddr_i];
  assign rdata_o = data_mem[raddr_i];
endmodule

// File: rtl/vfc_tpl_store.sv
module vfc_tpl_store #(
  parameter int NUM_CH  = 16,
  parameter int NUM_TPL = 4,
  localparam int TPL_W  = (NUM_TPL > 1) ? $clog2(NUM_TPL) : 1,
  localparam int CODE_W = 2 * NUM_CH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [TPL_W-1:0]  waddr_i,
  input  logic [CODE_W-1:0] wcodes_i,
  input  logic [TPL_W-1:0]  rsel_i,
  output logic [CODE_W-1:0] rcodes_o
);
  logic [CODE_W-1:0] tpl_q [NUM_TPL];

  // reset to all-mask so an unloaded template never drives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_TPL; i++) tpl_q[i] <= '0;
    end else if (we_i) begin
      tpl_q[waddr_i] <= wcodes_i;
    end
  end

  assign rcodes_o = tpl_q[rsel_i];
endmodule

// File: rtl/vfc_sector_cmp.sv
module vfc_sector_cmp
  import vfc_pkg::*;
#(
  parameter int SECT_CH = 8,
  localparam int CNT_W  = $clog2(SECT_CH + 1)
) (
  input  logic [2*SECT_CH-1:0] codes_i,
  input  logic [SECT_CH-1:0]   data_i,
  input  logic [SECT_CH-1:0]   pin_i,
  input  logic                 active_i,
  output logic [SECT_CH-1:0]   drv_en_o,
  output logic [SECT_CH-1:0]   drv_val_o,
  output logic [SECT_CH-1:0]   cmp_mask_o,
  output logic [SECT_CH-1:0]   mism_o,
  output logic [CNT_W-1:0]     mism_cnt_o
);
  for (genvar l = 0; l < SECT_CH; l++) begin : g_lane
    role_e role;
    assign role          = role_e'(codes_i[2*l +: 2]);
    assign drv_en_o[l]   = active_i && (role == ROLE_FORCE);
    assign drv_val_o[l]  = drv_en_o[l] & data_i[l];
    assign cmp_mask_o[l] = active_i && (role == ROLE_CMP);
    assign mism_o[l]     = cmp_mask_o[l] & (pin_i[l] ^ data_i[l]);
  end

  always_comb begin
    mism_cnt_o = '0;
    for (int l = 0; l < SECT_CH; l++) mism_cnt_o = mism_cnt_o + CNT_W'(mism_o[l]);
  end
endmodule

// File: rtl/vfc_fail_map.sv
module vfc_fail_map #(
  parameter int DEPTH  = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             set_i,
  input  logic [IDX_W-1:0] set_addr_i,
  input  logic             set_val_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic             flag_o
);
  logic [DEPTH-1:0] flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flags_q <= '0;
    else if (clr_i) flags_q <= '0;
    else if (set_i) flags_q[set_addr_i] <= set_val_i;
  end

  assign flag_o = flags_q[raddr_i];
endmodule

// File: rtl/vfc_engine.sv
module vfc_engine
  import vfc_pkg::*;
#(
  parameter int NUM_SECT  = 2,
  parameter int SECT_CH   = 8,
  parameter int VEC_DEPTH = 64,
  parameter int NUM_TPL   = 4,
  parameter int ERR_W     = 8,
  localparam int NUM_CH   = NUM_SECT * SECT_CH,
  localparam int IDX_W    = $clog2(VEC_DEPTH),
  localparam int TPL_W    = (NUM_TPL > 1) ? $clog2(NUM_TPL) : 1,
  localparam int SCNT_W   = $clog2(SECT_CH + 1),
  localparam int TCNT_W   = $clog2(NUM_CH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tpl_we_i,
  input  logic [TPL_W-1:0]    tpl_addr_i,
  input  logic [2*NUM_CH-1:0] tpl_codes_i,
  input  logic                vec_we_i,
  input  logic [IDX_W-1:0]    vec_addr_i,
  input  logic [TPL_W-1:0]    vec_tpl_i,
  input  logic [NUM_CH-1:0]   vec_data_i,
  input  logic [IDX_W-1:0]    last_idx_i,
  input  logic                start_i,
  output logic                done_o,
  output logic [NUM_CH-1:0]   drive_val_o,
  output logic [NUM_CH-1:0]   drive_en_o,
  input  logic [NUM_CH-1:0]   pin_i,
  input  logic                strobe_i,
  output logic [ERR_W-1:0]    err_cnt_o,
  output logic [IDX_W-1:0]    first_fail_o,
  output logic                first_fail_vld_o,
  input  logic [IDX_W-1:0]    fail_addr_i,
  output logic                fail_flag_o
);
  state_e              state_q;
  logic [IDX_W-1:0]    idx_q;
  logic [ERR_W-1:0]    err_q;
  logic [IDX_W-1:0]    first_q;
  logic                first_vld_q;
  logic                done_q;

  logic [TPL_W-1:0]    cur_tpl;
  logic [NUM_CH-1:0]   cur_data;
  logic [2*NUM_CH-1:0] cur_codes;
  logic [NUM_CH-1:0]   cmp_mask;
  logic [NUM_CH-1:0]   mism;
  logic [SCNT_W-1:0]   sect_cnt [NUM_SECT];
  logic [TCNT_W-1:0]   mism_total;
  logic [ERR_W:0]      err_sum;
  logic [ERR_W-1:0]    err_next;
  logic                active, start_ok, cmp_fire, any_mism, last_vec;

  vfc_vec_store #(.NUM_CH(NUM_CH), .DEPTH(VEC_DEPTH), .TPL_W(TPL_W)) u_vec_store (
    .clk_i   (clk_i),
    .we_i    (vec_we_i),
    .waddr_i (vec_addr_i),
    .wtpl_i  (vec_tpl_i),
    .wdata_i (vec_data_i),
    .raddr_i (idx_q),
    .rtpl_o  (cur_tpl),
    .rdata_o (cur_data)
  );

  vfc_tpl_store #(.NUM_CH(NUM_CH), .NUM_TPL(NUM_TPL)) u_tpl_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (tpl_we_i),
    .waddr_i  (tpl_addr_i),
    .wcodes_i (tpl_codes_i),
    .rsel_i   (cur_tpl),
    .rcodes_o (cur_codes)
  );

  assign active = (state_q != ST_IDLE);

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    vfc_sector_cmp #(.SECT_CH(SECT_CH)) u_sect (
      .codes_i    (cur_codes[2*SECT_CH*s +: 2*SECT_CH]),
      .data_i     (cur_data[SECT_CH*s +: SECT_CH]),
      .pin_i      (pin_i[SECT_CH*s +: SECT_CH]),
      .active_i   (active),
      .drv_en_o   (drive_en_o[SECT_CH*s +: SECT_CH]),
      .drv_val_o  (drive_val_o[SECT_CH*s +: SECT_CH]),
      .cmp_mask_o (cmp_mask[SECT_CH*s +: SECT_CH]),
      .mism_o     (mism[SECT_CH*s +: SECT_CH]),
      .mism_cnt_o (sect_cnt[s])
    );
  end

  always_comb begin
    mism_total = '0;
    for (int s = 0; s < NUM_SECT; s++) mism_total = mism_total + TCNT_W'(sect_cnt[s]);
  end

  assign start_ok = (state_q == ST_IDLE) && start_i;
  assign cmp_fire = (state_q == ST_STROBE) && strobe_i;
  assign any_mism = |mism;
  assign last_vec = (idx_q == last_idx_i);
  assign err_sum  = (ERR_W+1)'(err_q) + (ERR_W+1)'(mism_total);
  assign err_next = err_sum[ERR_W] ? '1 : err_sum[ERR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      err_q       <= '0;
      first_q     <= '0;
      first_vld_q <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_ok) begin
          state_q     <= ST_SETTLE;
          idx_q       <= '0;
          err_q       <= '0;
          first_q     <= '0;
          first_vld_q <= 1'b0;
          done_q      <= 1'b0;
        end
        ST_SETTLE: state_q <= ST_STROBE;  // turnaround clock, strobe ignored
        ST_STROBE: if (cmp_fire) begin
          err_q <= err_next;
          if (any_mism && !first_vld_q) begin
            first_q     <= idx_q;
            first_vld_q <= 1'b1;
          end
          if (last_vec) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_SETTLE;
            idx_q   <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  vfc_fail_map #(.DEPTH(VEC_DEPTH)) u_fail_map (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (start_ok),
    .set_i      (cmp_fire),
    .set_addr_i (idx_q),
    .set_val_i  (any_mism),
    .raddr_i    (fail_addr_i),
    .flag_o     (fail_flag_o)
  );

  assign done_o           = done_q;
  assign err_cnt_o        = err_q;
  assign first_fail_o     = first_q;
  assign first_fail_vld_o = first_vld_q;
endmodule

// File: rtl/vfc_engine_sva.sv
module vfc_engine_sva
  import vfc_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int IDX_W  = 6,
  parameter int ERR_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              strobe_i,
  input logic              done_o,
  input logic [NUM_CH-1:0] drive_en_o,
  input logic [ERR_W-1:0]  err_cnt_o,
  input logic [IDX_W-1:0]  first_fail_o,
  input logic              first_fail_vld_o,
  input state_e            state_q,
  input logic [NUM_CH-1:0] cmp_mask
);
  p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (drive_en_o == '0));

  p_no_fight_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STROBE && strobe_i) |->
      (((drive_en_o & cmp_mask) == '0) && (($past(drive_en_o) & cmp_mask) == '0)));

  p_settle_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SETTLE) |=> (state_q == ST_STROBE));

  p_strobe_adv_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STROBE && strobe_i) |=> (state_q != ST_STROBE));

  p_no_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> (err_cnt_o >= $past(err_cnt_o)));

  p_first_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_fail_vld_o && state_q != ST_IDLE) |=> (first_fail_vld_o && $stable(first_fail_o)));

  p_done_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (drive_en_o == '0));

  p_start_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i) |=>
      (err_cnt_o == '0 && !first_fail_vld_o && !done_o && state_q == ST_SETTLE));
endmodule

bind vfc_engine vfc_engine_sva #(
  .NUM_CH (NUM_CH),
  .IDX_W  (IDX_W),
  .ERR_W  (ERR_W)
) u_vfc_engine_sva (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .start_i          (start_i),
  .strobe_i         (strobe_i),
  .done_o           (done_o),
  .drive_en_o       (drive_en_o),
  .err_cnt_o        (err_cnt_o),
  .first_fail_o     (first_fail_o),
  .first_fail_vld_o (first_fail_vld_o),
  .state_q          (state_q),
  .cmp_mask         (cmp_mask)
);

// File: tb/vfc_engine_bench.sv
module vfc_engine_bench;
  localparam int NS = 2, SC = 8, NCH = 16, DEPTH = 64, NTPL = 4, ERRW = 8;
  localparam int IW = 6, TW = 2;
  localparam int ERR_MAX = (1 << ERRW) - 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            tpl_we = 1'b0;
  logic [TW-1:0]   tpl_addr = '0;
  logic [2*NCH-1:0] tpl_codes = '0;
  logic            vec_we = 1'b0;
  logic [IW-1:0]   vec_addr = '0;
  logic [TW-1:0]   vec_tpl = '0;
  logic [NCH-1:0]  vec_data = '0;
  logic [IW-1:0]   last_idx = '0;
  logic            start = 1'b0;
  logic            done;
  logic [NCH-1:0]  drv_val, drv_en;
  logic [NCH-1:0]  pin = '0;
  logic            strobe = 1'b0;
  logic [ERRW-1:0] err_cnt;
  logic [IW-1:0]   first_fail;
  logic            first_vld;
  logic [IW-1:0]   fail_addr = '0;
  logic            fail_flag;

  always #5 clk = ~clk;

  vfc_engine #(.NUM_SECT(NS), .SECT_CH(SC), .VEC_DEPTH(DEPTH), .NUM_TPL(NTPL), .ERR_W(ERRW))
  u_vfc_engine (
    .clk_i(clk), .rst_ni(rst_n),
    .tpl_we_i(tpl_we), .tpl_addr_i(tpl_addr), .tpl_codes_i(tpl_codes),
    .vec_we_i(vec_we), .vec_addr_i(vec_addr), .vec_tpl_i(vec_tpl), .vec_data_i(vec_data),
    .last_idx_i(last_idx), .start_i(start), .done_o(done),
    .drive_val_o(drv_val), .drive_en_o(drv_en), .pin_i(pin), .strobe_i(strobe),
    .err_cnt_o(err_cnt), .first_fail_o(first_fail), .first_fail_vld_o(first_vld),
    .fail_addr_i(fail_addr), .fail_flag_o(fail_flag)
  );

  logic [TW-1:0]    m_tpl   [DEPTH];
  logic [NCH-1:0]   m_data  [DEPTH];
  logic [2*NCH-1:0] m_codes [NTPL];
  bit               exp_fail[DEPTH];
  int n_chk = 0, n_err = 0;
  int exp_err, exp_first;
  bit exp_fvld;
  bit finished = 1'b0;

  function automatic logic [NCH-1:0] role_mask(input logic [2*NCH-1:0] codes, input logic [1:0] code);
    logic [NCH-1:0] m;
    for (int c = 0; c < NCH; c++) m[c] = (codes[2*c +: 2] == code);
    return m;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic load_tpl(input int t, input logic [2*NCH-1:0] codes);
    tpl_we = 1'b1; tpl_addr = TW'(t); tpl_codes = codes; m_codes[t] = codes;
    @(negedge clk); tpl_we = 1'b0;
  endtask

  task automatic load_vec(input int k, input int t, input logic [NCH-1:0] d);
    vec_we = 1'b1; vec_addr = IW'(k); vec_tpl = TW'(t); vec_data = d;
    m_tpl[k] = TW'(t); m_data[k] = d;
    @(negedge clk); vec_we = 1'b0;
  endtask

  task automatic start_run(input int last);
    last_idx = IW'(last); start = 1'b1;
    @(negedge clk); start = 1'b0;
    exp_err = 0; exp_first = 0; exp_fvld = 1'b0;
    for (int k = 0; k < DEPTH; k++) exp_fail[k] = 1'b0;
    chk(err_cnt == '0, "R9", "err cleared on start", 32'(err_cnt), 0);
    chk(!first_vld && !done, "R9", "first/done cleared", {30'd0, first_vld, done}, 0);
  endtask

  // entered at a falling edge in the settle clock of vector k
  task automatic do_vec(input int k, input logic [NCH-1:0] errm, input bit early, input bit start_mid);
    logic [NCH-1:0] fm, cm;
    int mis;
    fm = role_mask(m_codes[m_tpl[k]], 2'b01);
    cm = role_mask(m_codes[m_tpl[k]], 2'b10);
    chk(drv_en == fm, "R2", $sformatf("drive_en v%0d", k), 32'(drv_en), 32'(fm));
    chk(drv_val == (m_data[k] & fm), "R2", $sformatf("drive_val v%0d", k), 32'(drv_val), 32'(m_data[k] & fm));
    chk((drv_en & cm) == '0, "R3", $sformatf("compare pin released v%0d", k), 32'(drv_en & cm), 0);
    if (early) begin
      pin = ~m_data[k]; strobe = 1'b1;
    end
    @(negedge clk);
    strobe = 1'b0;
    if (early) begin
      chk(err_cnt == ERRW'(exp_err), "R3", "settle strobe ignored (err)", 32'(err_cnt), 32'(exp_err));
      chk(drv_en == fm, "R3", "settle strobe ignored (vector held)", 32'(drv_en), 32'(fm));
    end
    if (start_mid) start = 1'b1;
    pin = (((m_data[k] ^ errm) & cm)) | (~cm & NCH'($urandom));
    strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0; start = 1'b0;
    mis = $countones(errm & cm);
    exp_err = (exp_err + mis > ERR_MAX) ? ERR_MAX : exp_err + mis;
    if (mis != 0) begin
      exp_fail[k] = 1'b1;
      if (!exp_fvld) begin exp_fvld = 1'b1; exp_first = k; end
    end
    chk(err_cnt == ERRW'(exp_err), (mis == 0 && errm != 0) ? "R10" : "R4",
        $sformatf("err after v%0d", k), 32'(err_cnt), 32'(exp_err));
  endtask

  task automatic finish_run(input int last);
    chk(done == 1'b1, "R8", "done at last vector", 32'(done), 1);
    chk(drv_en == '0, "R8", "drives released", 32'(drv_en), 0);
    chk(err_cnt == ERRW'(exp_err), "R5", "final err count", 32'(err_cnt), 32'(exp_err));
    chk(first_vld == exp_fvld, "R6", "first valid", 32'(first_vld), 32'(exp_fvld));
    if (exp_fvld)
      chk(first_fail == IW'(exp_first), "R6", "first index", 32'(first_fail), 32'(exp_first));
    for (int k = 0; k <= last; k++) begin
      fail_addr = IW'(k); #1;
      chk(fail_flag == exp_fail[k], "R7", $sformatf("fail flag v%0d", k), 32'(fail_flag), 32'(exp_fail[k]));
    end
    @(negedge clk);
    chk(done && drv_en == '0, "R8", "engine stays stopped", {15'd0, done, drv_en}, 32'h10000);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(!done && drv_en == '0, "R1", "outputs in reset", {15'd0, done, drv_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(err_cnt == '0 && !first_vld, "R1", "counts after reset", {23'd0, first_vld, err_cnt}, 0);
  endtask

  task automatic t_mixed_roles;
    load_tpl(0, 32'h5555_5555);  // all force
    load_tpl(1, 32'hAAAA_AAAA);  // all compare
    load_tpl(2, 32'hAAAA_5555);  // sector 0 force, sector 1 compare
    load_tpl(3, 32'hE4E4_E4E4);  // mask, force, compare, reserved per lane
    for (int k = 0; k < 6; k++) load_vec(k, (k == 5) ? 0 : ((k == 4) ? 1 : k), NCH'(16'hA5C3 + k * 16'h1357));
    start_run(5);
    do_vec(0, 16'h0000, 1'b0, 1'b0);
    do_vec(1, 16'h0000, 1'b1, 1'b0);   // force->compare turnaround, early strobe
    do_vec(2, 16'h0200, 1'b0, 1'b0);
    do_vec(3, 16'h0009, 1'b0, 1'b0);   // mismatches only on masked lanes
    do_vec(4, 16'h0111, 1'b0, 1'b0);
    do_vec(5, 16'hFFFF, 1'b0, 1'b0);   // all forced, nothing compared
    finish_run(5);
  endtask

  task automatic t_saturate;
    for (int k = 0; k < 20; k++) load_vec(k, 1, NCH'(k * 3 + 1));
    start_run(19);
    for (int k = 0; k < 20; k++) do_vec(k, 16'hFFFF, 1'b0, 1'b0);
    finish_run(19);
  endtask

  task automatic t_restart;
    start_run(3);
    fail_addr = IW'(10); #1;
    chk(fail_flag == 1'b0, "R9", "old fail flag cleared", 32'(fail_flag), 0);
    do_vec(0, 16'h0001, 1'b0, 1'b0);
    do_vec(1, 16'h0002, 1'b0, 1'b1);   // start pulse mid-run must be ignored
    do_vec(2, 16'h0004, 1'b0, 1'b0);
    do_vec(3, 16'h0008, 1'b0, 1'b0);
    finish_run(3);
  endtask

  initial begin
    t_reset();
    t_mixed_roles();
    t_saturate();
    t_restart();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL R8 watchdog run not complete act=%0h exp=%0h", done, 1);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule